// File: doc/BRIEF.md
# External Interrupt Input Conditioner

The block accepts a small set of external interrupt pins and turns each one into a clean, active-high request for a downstream interrupt controller. Each pin is first brought into the local clock domain. It is then interpreted according to its own channel configuration: sensed as a level of either polarity, or as an edge of either direction. What leaves the block is always uniform. Level channels present an active-high level. Edge channels present a single-clock pulse. The controller downstream therefore only ever has to handle two input kinds.

Each channel owns one configuration word on a simple word-addressed register bus. Software enables the channel, selects level or edge sensing, and selects polarity. The polarity bit changes meaning with the mode. In level mode a set bit means active-high. In edge mode a set bit means the falling edge. Word offset 0x0 is reserved and reads as zero.

Top module: `xirq_cond`

## Requirements
- R1: The asynchronous active-low reset `rst_ni` clears every configuration word and every synchronizer and edge-history flop. After reset, every register reads zero and every `irq_o` bit is low.
- R2: Channel n's configuration word sits at byte address 4 + 4·n. It keeps bit 16 (enable), bit 9 (level select) and bit 8 (polarity), and each of these bits reads back as written.
- R3: Every other bit of a configuration word reads zero. The word at address 0x0 and every unmapped address read zero, and writes to them change no configuration state.
- R4: While bit 16 of a channel's word is clear, that channel's `irq_o` bit stays low whatever its pin does.
- R5: With bit 9 = 1 and bit 8 = 1, `irq_o[n]` follows `pin_i[n]`. It is valid three clock edges after the pin changes (two synchronizer flops plus an output flop).
- R6: With bit 9 = 1 and bit 8 = 0, `irq_o[n]` is the inverse of `pin_i[n]`, with the same three-edge latency.
- R7: With bit 9 = 0 and bit 8 = 0, each low-to-high pin transition produces exactly one clock cycle of `irq_o[n]` high, three edges later. High-to-low transitions produce nothing.
- R8: With bit 9 = 0 and bit 8 = 1, each high-to-low pin transition produces exactly one clock cycle of `irq_o[n]` high, three edges later. Low-to-high transitions produce nothing.
- R9: Enabling a channel in an edge mode while its pin already rests at the post-edge value produces no pulse.
- R10: The channels are independent. Configuring or stimulating one channel does not change the other channel's output.
- R11: Writing zero to a channel's word disables it. Its `irq_o` bit is low from the cycle after the write, and the word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register bus select |
| bus_enable_i | input | 1 | Register bus access phase |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data; zero when not selected |
| pin_i | input | NUM_CH | External interrupt pins, asynchronous |
| irq_o | output | NUM_CH | Normalized active-high requests |

## Verification
On every cycle, the bound checker confirms four properties. A disabled channel's request is low on the following cycle. An edge-mode request never lasts two cycles while the configuration holds. A write to a channel word lands in the stored fields. Reserved bits and the reserved word always read as zero. The bench scenarios are the only place where polarity meaning, exact three-edge latency, the absence of a pulse at enable time, and channel independence show up, because those depend on the pin history the bench drives and on the cycle in which each result appears.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EN_BIT  = 16;
  localparam int unsigned LVL_BIT = 9;
  localparam int unsigned POL_BIT = 8;
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << LVL_BIT) | (DATA_W'(1) << POL_BIT);

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } chan_cfg_t;

  function automatic chan_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
    chan_cfg_t c;
    c.en  = w[EN_BIT];
    c.lvl = w[LVL_BIT];
    c.pol = w[POL_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(chan_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]  = c.en;
    w[LVL_BIT] = c.lvl;
    w[POL_BIT] = c.pol;
    return w;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_i,
  input  logic                     enable_i,
  input  logic                     write_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              wr_stb;
  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic [DATA_W-1:0] rd_mux;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign wr_stb   = sel_i & enable_i & write_i;

  // word 0 is reserved; channel n lives at word n+1
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[ch] <= '0;
      else if (wr_stb && word_idx == WORD_W'(ch + 1))
        cfg_q[ch] <= word_to_cfg(wdata_i);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (word_idx == WORD_W'(ch + 1)) rd_mux = cfg_to_word(cfg_q[ch]);
    end
  end

  assign rdata_o = sel_i ? rd_mux : '0;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
  import xirq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  chan_cfg_t cfg_i,
  output logic      irq_o
);
  logic hist_q;
  logic irq_q;
  logic hit;

  always_comb begin
    case ({cfg_i.lvl, cfg_i.pol})
      2'b11:   hit = lvl_i;             // level, active high
      2'b10:   hit = ~lvl_i;            // level, active low
      2'b00:   hit = lvl_i & ~hist_q;   // rising edge
      default: hit = ~lvl_i & hist_q;   // falling edge
    endcase
  end

  // history tracks even while disabled so enabling cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hist_q <= lvl_i;
      irq_q  <= cfg_i.en & hit;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_enable_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] irq_o
);
  chan_cfg_t [NUM_CH-1:0] cfg_w;
  logic [NUM_CH-1:0]      sync_w;

  xirq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .enable_i (bus_enable_i),
    .write_i  (bus_write_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .cfg_o    (cfg_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i[ch]),
      .q_o    (sync_w[ch])
    );

    xirq_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (sync_w[ch]),
      .cfg_i  (cfg_w[ch]),
      .irq_o  (irq_o[ch])
    );
  end
endmodule

// File: rtl/xirq_cond_chk.sv
module xirq_cond_chk
  import xirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_sel_i,
  input logic                   bus_enable_i,
  input logic                   bus_write_i,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic [31:0]            bus_wdata_i,
  input logic [31:0]            bus_rdata_o,
  input logic [NUM_CH-1:0]      irq_o,
  input chan_cfg_t [NUM_CH-1:0] cfg_i
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  AST_RSVD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & ~CFG_MASK) == '0); // R3

  AST_RSVD_WORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_addr_i[ADDR_W-1:2] == '0) |-> bus_rdata_o == '0); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i[c].en |=> !irq_o[c]); // R4

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && !cfg_i[c].lvl && $stable(cfg_i[c])) |=> !irq_o[c]); // R7

    AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && bus_enable_i && bus_write_i &&
       bus_addr_i[ADDR_W-1:2] == WORD_W'(c + 1))
      |=> (cfg_i[c].en  == $past(bus_wdata_i[EN_BIT]) &&
           cfg_i[c].lvl == $past(bus_wdata_i[LVL_BIT]) &&
           cfg_i[c].pol == $past(bus_wdata_i[POL_BIT]))); // R2
  end
endmodule

bind xirq_cond xirq_cond_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_sel_i    (bus_sel_i),
  .bus_enable_i (bus_enable_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .cfg_i        (cfg_w)
);

// File: tb/sim_xirq_cond.sv
module sim_xirq_cond;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bus_sel_i = 1'b0;
  logic              bus_enable_i = 1'b0;
  logic              bus_write_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic [NUM_CH-1:0] pin_i = '0;
  logic [NUM_CH-1:0] irq_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    when;
    int    ch;
    bit    val;
    string req;
  } exp_t;
  exp_t sb_q[$];

  xirq_cond #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare queued expectations at the negedge of their cycle
  always @(negedge clk_i) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].when == cyc) begin
        chk(sb_q[i].req, 32'(irq_o[sb_q[i].ch]), 32'(sb_q[i].val));
        sb_q.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic push(int dly, int ch, bit val, string req);
    exp_t e;
    e.when = cyc + dly;
    e.ch = ch;
    e.val = val;
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_sel_i = 1; bus_enable_i = 1; bus_write_i = 1;
    bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 0; bus_enable_i = 0; bus_write_i = 0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    bus_sel_i = 1; bus_addr_i = a;
    #1;
    chk(req, bus_rdata_o, exp);
    bus_sel_i = 0;
  endtask

  // pin changed at this negedge: result appears after three edges
  task automatic exp_level(int ch, bit val, string req);
    push(2, ch, ~val, req);
    push(3, ch, val, req);
  endtask

  task automatic exp_pulse(int ch, string req);
    push(2, ch, 0, req);
    push(3, ch, 1, req);
    push(4, ch, 0, req);
  endtask

  task automatic exp_quiet(int ch, string req);
    for (int d = 1; d <= 5; d++) push(d, ch, 0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(1);
    // R1: reset state
    bus_rd(8'h00, 32'h0, "R1 word0");
    bus_rd(8'h04, 32'h0, "R1 ch0");
    bus_rd(8'h08, 32'h0, "R1 ch1");
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R2/R3: readback and reserved space
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, 32'h0001_0300, "R2 ch0 masked");
    bus_wr(8'h08, 32'h0000_0300);
    bus_rd(8'h08, 32'h0000_0300, "R2 ch1");
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'h0, "R3 word0");
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, 32'h0, "R3 unmapped");
    bus_rd(8'h04, 32'h0001_0300, "R3 ch0 untouched");
    bus_rd(8'h08, 32'h0000_0300, "R3 ch1 untouched");

    // R4: ch1 has lvl/pol but no enable
    pin_i[1] = 1;
    exp_quiet(1, "R4 disabled");
    tick(6);

    // R5: ch0 active-high level
    pin_i[0] = 1;
    exp_level(0, 1, "R5 rise");
    tick(6);
    pin_i[0] = 0;
    exp_level(0, 0, "R5 fall");
    tick(6);

    // R6: ch1 active-low level, pin1 high -> low request
    bus_wr(8'h08, 32'h0001_0200);
    tick(4);
    chk("R6 high pin", 32'(irq_o[1]), 32'h0);
    pin_i[1] = 0;
    exp_level(1, 1, "R6 low pin");
    exp_quiet(0, "R10 ch0 unaffected");
    tick(6);

    // R9/R7: enable rising mode with pin already high
    pin_i[0] = 1;
    tick(6);
    bus_wr(8'h04, 32'h0001_0000);
    exp_quiet(0, "R9 rising enable");
    tick(6);
    pin_i[0] = 0;
    exp_quiet(0, "R7 falling ignored");
    tick(6);
    pin_i[0] = 1;
    exp_pulse(0, "R7 pulse");
    tick(6);

    // R9/R8: enable falling mode with pin1 low
    bus_wr(8'h08, 32'h0001_0100);
    exp_quiet(1, "R9 falling enable");
    tick(6);
    pin_i[1] = 1;
    exp_quiet(1, "R8 rising ignored");
    tick(6);
    pin_i[1] = 0;
    exp_pulse(1, "R8 pulse");
    tick(6);

    // R10: simultaneous edges on both channels
    pin_i[0] = 0;
    pin_i[1] = 1;
    tick(6);
    pin_i = 2'b01;
    exp_pulse(0, "R10 ch0");
    exp_pulse(1, "R10 ch1");
    tick(6);

    // R11: level-high active, then write zero
    bus_wr(8'h04, 32'h0001_0300);
    tick(3);
    chk("R11 active before", 32'(irq_o[0]), 32'h1);
    bus_wr(8'h04, 32'h0);
    push(1, 0, 0, "R11 disabled");
    push(3, 0, 0, "R11 stays low");
    bus_rd(8'h04, 32'h0, "R11 readback");
    tick(6);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule